// File: doc/BRIEF.md
# Two-Wire Slave Address Matcher

This block sits next to a two-wire serial bus (I2C-style) and decides whether the address byte that follows a Start condition selects this device as a slave. It passes the clock and data lines through a two-stage synchroniser. It detects Start conditions and shifts in seven address bits followed by one direction bit. The received address is compared with a programmable own address, and also with the general call address when that check is enabled.

On a hit the block gives a one-cycle match pulse, a general-call flag and the received direction bit. It then pulls the data line low during the acknowledge slot, unless software has set the acknowledge level to not-acknowledge. On a miss it leaves the data line released and ignores the bus until the next Start. Data bytes after the address and master operation are handled elsewhere.

The state machine has five states:
- IDLE waits for a Start.
- SHIFT collects the eight bits.
- ACK_WAIT waits for the clock to fall after the eighth bit.
- ACK_DRIVE holds the acknowledge level for one clock low-and-high period.
- SKIP ignores the bus.

The transitions are as follows:
- A Start moves every state to SHIFT and clears the bit count.
- In SHIFT, the eighth clock rise goes to ACK_WAIT on a hit and to SKIP on a miss.
- ACK_WAIT goes to ACK_DRIVE on a clock fall.
- ACK_DRIVE goes to SKIP on the next clock fall.
- IDLE and SKIP leave only on a Start.

Top module: `tw_addr_match`

## Requirements
- R1: After reset `match_pulse`, `gc_hit`, `rw_bit` and `sda_drive_low` are 0, and the block waits for a Start.
- R2: A Start is a falling edge of the synchronised data line while the synchronised clock is high. After a Start, eight bits are sampled, one on each rising clock edge.
- R3: The first address bit received is compared with `own_addr[6]` and the seventh with `own_addr[0]`. An own-address hit requires `own_addr[7]` = 1.
- R4: When `gc_en` = 1 and all eight received bits are 0, the byte is a hit and `gc_hit` becomes 1. With `gc_en` = 0 an all-zero byte gives no general-call hit. An address of 0 with direction bit 1 never gives a general-call hit.
- R5: Each hit produces exactly one `match_pulse` of one clock cycle. `rw_bit` takes the eighth received bit in that same cycle and holds it. `gc_hit` holds until the next Start.
- R6: After a hit, `sda_drive_low` equals the inverse of `ack_level`, sampled when the clock falls after the eighth bit. It stays at that value until the following clock fall and is 0 afterwards (`ack_level` = 1 means not-acknowledge).
- R7: After a miss there is no pulse and `sda_drive_low` stays 0. Further bytes are ignored until the next Start, even when they would match.
- R8: A Start that arrives part-way through an address restarts the bit count, so only the eight bits after the latest Start are compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| own_addr | input | 8 | Bit 7 is the own-address enable; bits 6..0 are the own address |
| gc_en | input | 1 | Enables general call matching |
| ack_level | input | 1 | Level sent in the acknowledge slot (1 = not-acknowledge) |
| match_pulse | output | 1 | One-cycle pulse when an address byte hits |
| gc_hit | output | 1 | The last hit was a general call |
| rw_bit | output | 1 | Direction bit of the last hit |
| sda_drive_low | output | 1 | Pull the data line low (open-drain enable) |

## Verification
Random address bytes run against random own addresses, with the enable bits toggled. Half of the bytes are forced to equal the own address, which separates a true compare from a stuck result and a reversed bit order. Directed all-zero bytes run with general call on and off, and address 0 runs with the direction bit set. These cases separate the general-call path from the own-address path. Further directed cases cover a not-acknowledge setting, a matching byte sent after a miss without a fresh Start, and a Start that arrives three bits into an address. Together they show acknowledge polarity, the ignore behaviour and the bit-count restart.

// File: rtl/twm_pkg.sv
package twm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_SKIP
    } twm_state_e;
endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    for (genvar w = 0; w < WIDTH; w++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d_async[w]};
        end
        assign d_sync[w] = chain[STAGES-1];
    end
endmodule

// File: rtl/twm_cond.sv
module twm_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign start_det = scl_q & scl_s & sda_q & ~sda_s;
    assign scl_rise  = ~scl_q & scl_s;
    assign scl_fall  = scl_q & ~scl_s;
endmodule

// File: rtl/tw_addr_match.sv
module tw_addr_match
    import twm_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W:0]   own_addr,
    input  logic              gc_en,
    input  logic              ack_level,
    output logic              match_pulse,
    output logic              gc_hit,
    output logic              rw_bit,
    output logic              sda_drive_low
);
    localparam int CNT_W = $clog2(ADDR_W + 2);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_W);

    logic [1:0] line_s;
    logic scl_s, sda_s;
    logic start_det, scl_rise, scl_fall;
    twm_state_e state, nxt;
    logic [ADDR_W-1:0] shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic last_bit, own_hit_c, gc_hit_c, hit_c;

    twm_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({scl_in, sda_in}), .d_sync(line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    twm_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .start_det(start_det), .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    assign last_bit  = (bit_cnt == LAST);
    assign own_hit_c = own_addr[ADDR_W] && (shreg == own_addr[ADDR_W-1:0]);
    assign gc_hit_c  = gc_en && (shreg == '0) && !sda_s;
    assign hit_c     = own_hit_c || gc_hit_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_SHIFT;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_SHIFT:     if (scl_rise && last_bit) nxt = hit_c ? ST_ACK_WAIT : ST_SKIP;
                ST_ACK_WAIT:  if (scl_fall) nxt = ST_ACK_DRIVE;
                ST_ACK_DRIVE: if (scl_fall) nxt = ST_SKIP;
                ST_SKIP:      nxt = ST_SKIP;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg         <= '0;
            bit_cnt       <= '0;
            match_pulse   <= 1'b0;
            gc_hit        <= 1'b0;
            rw_bit        <= 1'b0;
            sda_drive_low <= 1'b0;
        end else begin
            match_pulse <= 1'b0;
            if (start_det) begin
                bit_cnt <= '0;
                gc_hit  <= 1'b0;
            end else if (state == ST_SHIFT && scl_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (last_bit) begin
                    if (hit_c) begin
                        match_pulse <= 1'b1;
                        rw_bit      <= sda_s;
                        gc_hit      <= gc_hit_c;
                    end
                end else begin
                    shreg <= {shreg[ADDR_W-2:0], sda_s};
                end
            end
            if (nxt == ST_ACK_DRIVE)
                sda_drive_low <= (state == ST_ACK_WAIT) ? !ack_level : sda_drive_low;
            else
                sda_drive_low <= 1'b0;
        end
    end

    // R5: a match pulse lasts exactly one cycle
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);
    // R2 / R8: every Start puts the shifter back at bit zero
    a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_SHIFT && bit_cnt == '0));
    // R7: the line is never pulled while idle or skipping
    a_r7_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_SKIP) |-> !sda_drive_low);
    // R6: the drive starts only from the acknowledge wait
    a_r6_drive_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> ($past(state) == ST_ACK_WAIT && state == ST_ACK_DRIVE));
    // R4: a general-call hit always carries a write direction
    a_r4_gc_write: assert property (@(posedge clk) disable iff (!rst_n)
        (match_pulse && gc_hit) |-> !rw_bit);
    // R3: an own-address hit needs the enable bit
    a_r3_own_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (match_pulse && !gc_hit) |-> $past(own_addr[ADDR_W]));
endmodule

// File: tb/tw_addr_match_test.sv
module tw_addr_match_test;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_scl = 1'b1, tb_sda = 1'b1;
    logic sda_bus;
    logic [7:0] own_addr = 8'h00;
    logic gc_en = 1'b0, ack_level = 1'b0;
    logic match_pulse, gc_hit, rw_bit, sda_drive_low;

    int errors = 0, checks = 0, pulses = 0;
    bit done = 0;

    assign sda_bus = tb_sda & ~sda_drive_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_addr_match uut (
        .clk(clk), .rst_n(rst_n), .scl_in(tb_scl), .sda_in(sda_bus),
        .own_addr(own_addr), .gc_en(gc_en), .ack_level(ack_level),
        .match_pulse(match_pulse), .gc_hit(gc_hit), .rw_bit(rw_bit),
        .sda_drive_low(sda_drive_low)
    );

    always @(posedge clk) if (rst_n && match_pulse) pulses++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit exp_own(input logic [7:0] byt, input logic [7:0] own);
        return own[7] && (byt[7:1] == own[6:0]);
    endfunction

    function automatic bit exp_gc(input logic [7:0] byt, input logic g);
        return g && (byt == 8'h00);
    endfunction

    task automatic bus_start();
        tb_sda = 1'b1; wt(PH);
        tb_scl = 1'b1; wt(PH);
        tb_sda = 1'b0; wt(PH);
        tb_scl = 1'b0; wt(PH);
    endtask

    task automatic bus_stop();
        tb_sda = 1'b0; wt(PH);
        tb_scl = 1'b1; wt(PH);
        tb_sda = 1'b1; wt(PH);
    endtask

    task automatic send_bit(input logic b);
        tb_sda = b;    wt(PH);
        tb_scl = 1'b1; wt(PH);
        tb_scl = 1'b0; wt(PH);
    endtask

    task automatic send_byte(input logic [7:0] byt);
        for (int i = 7; i >= 0; i--) send_bit(byt[i]);
    endtask

    // ack slot: checks the drive level while clock low, high, and after
    task automatic ack_slot(input string req, input bit exp_drive);
        tb_sda = 1'b1; wt(PH);
        check({req, " drive low phase"}, sda_drive_low, exp_drive);
        tb_scl = 1'b1; wt(PH);
        check({req, " drive high phase"}, sda_drive_low, exp_drive);
        tb_scl = 1'b0; wt(PH);
        check({req, " released after slot"}, sda_drive_low, 0);
    endtask

    task automatic addr_xfer(input string req, input logic [7:0] byt,
                             input logic [7:0] own, input logic g, input logic al);
        bit hit, gch;
        own_addr = own; gc_en = g; ack_level = al;
        hit = exp_own(byt, own) || exp_gc(byt, g);
        gch = exp_gc(byt, g);
        pulses = 0;
        bus_start();
        send_byte(byt);
        ack_slot(req, hit && !al);
        check({req, " pulse count"}, pulses, hit ? 1 : 0);
        if (hit) begin
            check({req, " gc flag"}, gc_hit, gch);
            check({req, " rw bit"}, rw_bit, byt[0]);
        end
        bus_stop();
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed1234);
        wt(3);
        // R1 reset state
        check("R1 match_pulse", match_pulse, 0);
        check("R1 gc_hit", gc_hit, 0);
        check("R1 rw_bit", rw_bit, 0);
        check("R1 sda_drive_low", sda_drive_low, 0);
        rst_n = 1'b1; wt(4);

        // R3 directed: own addr 0x5A, read and write
        addr_xfer("R3 own write", {7'h5A, 1'b0}, 8'h80 | 8'h5A, 1'b0, 1'b0);
        addr_xfer("R5 own read", {7'h5A, 1'b1}, 8'h80 | 8'h5A, 1'b0, 1'b0);
        // R3 bit order: reversed address must miss
        addr_xfer("R3 reversed order", {7'h2D, 1'b0}, 8'h80 | 8'h5A, 1'b0, 1'b0);
        // R3 enable off
        addr_xfer("R3 enable off", {7'h5A, 1'b0}, 8'h5A, 1'b0, 1'b0);
        // R4 general call
        addr_xfer("R4 gc on", 8'h00, 8'h80 | 8'h33, 1'b1, 1'b0);
        addr_xfer("R4 gc off", 8'h00, 8'h80 | 8'h33, 1'b0, 1'b0);
        addr_xfer("R4 gc read", 8'h01, 8'h80 | 8'h33, 1'b1, 1'b0);
        // R6 not-acknowledge
        addr_xfer("R6 nack", {7'h33, 1'b0}, 8'h80 | 8'h33, 1'b0, 1'b1);

        // R5 gc_hit held after own match is 0, then cleared by Start
        addr_xfer("R5 gc then", 8'h00, 8'h80 | 8'h11, 1'b1, 1'b0);
        check("R5 gc_hit held", gc_hit, 1);
        bus_start();
        check("R5 gc_hit cleared by start", gc_hit, 0);
        bus_stop();

        // R7: miss, then a matching byte without a Start is ignored
        own_addr = 8'h80 | 8'h22; gc_en = 1'b0; ack_level = 1'b0; pulses = 0;
        bus_start();
        send_byte({7'h23, 1'b0});
        ack_slot("R7 miss", 1'b0);
        send_byte({7'h22, 1'b0});
        ack_slot("R7 ignored byte", 1'b0);
        check("R7 no pulse", pulses, 0);
        bus_stop();

        // R8: Start in the middle of an address
        own_addr = 8'h80 | 8'h4C; pulses = 0;
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        tb_sda = 1'b1; wt(PH);
        bus_start();
        send_byte({7'h4C, 1'b1});
        ack_slot("R8 restart", 1'b1);
        check("R8 pulse count", pulses, 1);
        check("R8 rw", rw_bit, 1);
        bus_stop();

        // R2/R3/R4/R5 random
        for (int i = 0; i < 40; i++) begin
            logic [7:0] own, byt;
            logic g, al;
            own = 8'($urandom);
            byt = 8'($urandom);
            g   = 1'($urandom);
            al  = 1'($urandom);
            if (i % 2 == 0) byt[7:1] = own[6:0];
            if (i % 7 == 3) byt = 8'h00;
            addr_xfer("R2 random", byt, own, g, al);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule